// File: doc/BRIEF.md
# System Controller Register Bank

This block is a 32-bit memory-mapped slave that gathers the small housekeeping functions of a system on one fixed map of sixteen words. The map holds a GPIO input and output port, a GPIO interrupt-enable mask, two identical compare timers, a configuration-port status word, a capabilities word and a read-only system identifier. Software reaches every register through a plain valid/write/address/data bus. The byte address is turned into a word index, and only aligned 32-bit accesses take effect.

Some writes have side effects beyond the register contents. A write of any value to the identifier word issues a one-cycle system-reset request. A write to the configuration-port word carrying a specific command code issues a one-cycle shutdown request. Each timer counts up toward its compare value and raises its own interrupt pulse on a match. Read data is combinational from the address, so a read completes in the cycle in which the address is presented.

Top module: `sc_regbank`

## Requirements
- R1: The word index is the byte address shifted right by two. Accesses with a non-zero byte offset (address bits 1:0) are ignored, and a read at such an address returns 0. Word 1 (GPIO output) and word 2 (GPIO interrupt enable) are read/write, drive the `gpio_out` and `gpio_irq_en` pins, and read back zero-extended.
- R2: After reset, word 13 reads 0x1 (ready), word 14 reads the capabilities value (default 0), word 15 reads 0x10014D31, word 0 reads the strap value 0x1, and the timer words, GPIO output, interrupt enable and every request and interrupt output are 0.
- R3: Writes to word 0, word 13, word 14 and word 15 leave their read values unchanged.
- R4: Words 3, 7, 11 and 12, and any word index of 16 or above, read 0, and writes to them change nothing.
- R5: A write to word 15 drives `sys_reset_req` high for exactly the one cycle after the write edge.
- R6: A write to word 13 whose bits 15:0 equal 0x000E drives `shutdown_req` high for the one cycle after the write edge. Any other value leaves it low.
- R7: `gpio_in` passes through two flops before it appears in word 0. A change becomes visible after the second rising edge.
- R8: The timer words are: timer 0 control/compare/counter at words 4/5/6, and timer 1 at words 8/9/10. Control bit 0 enables counting and bit 1 selects auto-restart. Control reads back bits 1:0 only. While enabled, the counter rises by one per cycle, and a read of the counter word returns the live count.
- R9: On an enabled cycle where the counter equals the compare value, the counter returns to 0 and that timer's `timer_irq` bit is high during the following cycle. Without auto-restart, the enable bit clears at the same edge. With auto-restart, counting continues.
- R10: A bus write to any word of a timer takes priority over counting in that cycle. The written field takes the bus value, the counter does not advance, no match is taken, and the interrupt is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| gpio_in | input | GPIO_IN_W (8) | Asynchronous GPIO inputs |
| gpio_out | output | GPIO_OUT_W (8) | GPIO output register |
| gpio_irq_en | output | GPIO_IN_W (8) | GPIO interrupt-enable mask |
| timer_irq | output | 2 | Per-timer match interrupt pulses |
| sys_reset_req | output | 1 | System-reset request pulse |
| shutdown_req | output | 1 | Shutdown request pulse |

## Verification
The two functions that can land on the same edge are a timer's own compare match and a bus write to that timer's registers. The bench lets timer 0 run in auto-restart mode with a small compare value. It times a rewrite of the control word to fall on the exact edge where the counter equals the compare value. The result is judged at the ports. The counter read must still hold the compare value, the interrupt must stay low for that cycle, and the match must then be taken on the next edge, with the interrupt rising and the counter reading 0.

// File: rtl/sc_pkg.sv
// Shared constants for the system controller register bank: word map,
// timer control bit positions and the shutdown command code.
package sc_pkg;
    localparam int DATA_W     = 32;
    localparam int MAP_WORDS  = 16;
    localparam int NUM_TIMERS = 2;
    localparam int TMR_BASE   = 4;   // first timer control word
    localparam int TMR_STRIDE = 4;   // words between timer blocks
    localparam int TMR_CMP_OFS = 1;
    localparam int TMR_CNT_OFS = 2;

    localparam int W_GPIO_IN  = 0;
    localparam int W_GPIO_OUT = 1;
    localparam int W_GPIO_IEN = 2;
    localparam int W_CFGPORT  = 13;
    localparam int W_CAPS     = 14;
    localparam int W_SYSID    = 15;

    localparam int CTL_EN   = 0;
    localparam int CTL_AUTO = 1;
    localparam int CTL_W    = 2;

    localparam logic [15:0] SHUTDOWN_CODE = 16'h000E;
endpackage

// File: rtl/sc_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent (no multi-bit coherency required).
// Both stages reset to RST_VAL, so the output shows that value until
// two edges after reset is released.
module sc_sync #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift the input through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/sc_decode.sv
// Write-strobe decoder: turns an aligned, valid write into a one-hot
// strobe over the map words. Words outside the map give no strobe.
module sc_decode #(
    parameter int WW    = 4,
    parameter int WORDS = 16
) (
    input  logic            acc_ok,
    input  logic            is_write,
    input  logic [WW-1:0]   word,
    output logic [WORDS-1:0] wr_stb
);
    for (genvar i = 0; i < WORDS; i++) begin : g_stb
        assign wr_stb[i] = acc_ok && is_write && (word == WW'(i));
    end
endmodule

// File: rtl/sc_timer.sv
// Up-counting compare timer. Assumes its three write strobes come from
// a one-hot decoder. A bus write wins over counting in its cycle. On an
// enabled match the counter clears, irq pulses in the next cycle, and the
// enable bit clears unless auto-restart is set.
module sc_timer #(
    parameter int W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctrl_we,
    input  logic                   cmp_we,
    input  logic                   cnt_we,
    input  logic [W-1:0]           wdata,
    output logic [sc_pkg::CTL_W-1:0] ctrl_q,
    output logic [W-1:0]           cmp_q,
    output logic [W-1:0]           cnt_q,
    output logic                   irq
);
    import sc_pkg::*;

    logic bus_hit;
    logic match;

    assign bus_hit = ctrl_we | cmp_we | cnt_we;
    assign match   = (cnt_q == cmp_q);

    // Register update: bus write first, then count or match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
            cnt_q  <= '0;
            irq    <= 1'b0;
        end else if (bus_hit) begin
            if (ctrl_we) ctrl_q <= wdata[CTL_W-1:0];
            if (cmp_we)  cmp_q  <= wdata;
            if (cnt_we)  cnt_q  <= wdata;
            irq <= 1'b0;
        end else if (ctrl_q[CTL_EN]) begin
            if (match) begin
                cnt_q <= '0;
                irq   <= 1'b1;
                if (!ctrl_q[CTL_AUTO]) ctrl_q[CTL_EN] <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                irq   <= 1'b0;
            end
        end else begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/sc_regbank.sv
// System controller register bank. A fixed sixteen-word map holds GPIO,
// two compare timers, a configuration-port status word, capabilities and
// the system ID. Assumes aligned 32-bit accesses; others are ignored.
// Read data is combinational from the address. Writes take effect at
// the clock edge on which bus_valid and bus_write are high.
module sc_regbank #(
    parameter int          ADDR_W     = 6,
    parameter int          GPIO_IN_W  = 8,
    parameter int          GPIO_OUT_W = 8,
    parameter logic [31:0] SYS_ID     = 32'h10014D31,
    parameter logic [31:0] CAPS       = 32'h0000_0000,
    parameter logic [GPIO_IN_W-1:0] STRAP = GPIO_IN_W'(1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [GPIO_IN_W-1:0]    gpio_in,
    output logic [GPIO_OUT_W-1:0]   gpio_out,
    output logic [GPIO_IN_W-1:0]    gpio_irq_en,
    output logic [1:0]              timer_irq,
    output logic                    sys_reset_req,
    output logic                    shutdown_req
);
    import sc_pkg::*;

    localparam int WW = ADDR_W - 2;

    logic [WW-1:0]         word;
    logic                  aligned;
    logic                  acc_ok;
    logic                  in_map;
    logic [MAP_WORDS-1:0]  wr_stb;
    logic [GPIO_IN_W-1:0]  gpio_sync;
    logic                  cfg_ready;
    logic [DATA_W-1:0]     rd_words [MAP_WORDS];

    logic [CTL_W-1:0]  t_ctrl [NUM_TIMERS];
    logic [DATA_W-1:0] t_cmp  [NUM_TIMERS];
    logic [DATA_W-1:0] t_cnt  [NUM_TIMERS];

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign acc_ok  = bus_valid && aligned;
    assign in_map  = (int'(word) < MAP_WORDS);

    sc_decode #(.WW(WW), .WORDS(MAP_WORDS)) u_dec (
        .acc_ok   (acc_ok),
        .is_write (bus_write),
        .word     (word),
        .wr_stb   (wr_stb)
    );

    sc_sync #(.W(GPIO_IN_W), .RST_VAL(STRAP)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gpio_in),
        .q     (gpio_sync)
    );

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        localparam int BASE = TMR_BASE + TMR_STRIDE * t;
        sc_timer #(.W(DATA_W)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (wr_stb[BASE]),
            .cmp_we  (wr_stb[BASE + TMR_CMP_OFS]),
            .cnt_we  (wr_stb[BASE + TMR_CNT_OFS]),
            .wdata   (bus_wdata),
            .ctrl_q  (t_ctrl[t]),
            .cmp_q   (t_cmp[t]),
            .cnt_q   (t_cnt[t]),
            .irq     (timer_irq[t])
        );
    end

    // GPIO output and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpio_out    <= '0;
            gpio_irq_en <= '0;
        end else begin
            if (wr_stb[W_GPIO_OUT]) gpio_out    <= bus_wdata[GPIO_OUT_W-1:0];
            if (wr_stb[W_GPIO_IEN]) gpio_irq_en <= bus_wdata[GPIO_IN_W-1:0];
        end
    end

    // Configuration-port status: ready after reset, never cleared here.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_ready <= 1'b1;
        else        cfg_ready <= 1'b1;
    end

    // One-cycle request pulses for reset and shutdown writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_reset_req <= 1'b0;
            shutdown_req  <= 1'b0;
        end else begin
            sys_reset_req <= wr_stb[W_SYSID];
            shutdown_req  <= wr_stb[W_CFGPORT] && (bus_wdata[15:0] == SHUTDOWN_CODE);
        end
    end

    // Assemble the word map; reserved words stay zero.
    always_comb begin
        for (int i = 0; i < MAP_WORDS; i++) rd_words[i] = '0;
        rd_words[W_GPIO_IN]  = DATA_W'(gpio_sync);
        rd_words[W_GPIO_OUT] = DATA_W'(gpio_out);
        rd_words[W_GPIO_IEN] = DATA_W'(gpio_irq_en);
        for (int t = 0; t < NUM_TIMERS; t++) begin
            rd_words[TMR_BASE + TMR_STRIDE*t]               = DATA_W'(t_ctrl[t]);
            rd_words[TMR_BASE + TMR_STRIDE*t + TMR_CMP_OFS] = t_cmp[t];
            rd_words[TMR_BASE + TMR_STRIDE*t + TMR_CNT_OFS] = t_cnt[t];
        end
        rd_words[W_CFGPORT] = DATA_W'(cfg_ready);
        rd_words[W_CAPS]    = CAPS;
        rd_words[W_SYSID]   = SYS_ID;
    end

    // Read mux: aligned, in-map addresses only.
    always_comb begin
        bus_rdata = '0;
        if (aligned && in_map) bus_rdata = rd_words[word[3:0]];
    end
endmodule

// File: rtl/sc_regbank_chk.sv
// Assertion checker for sc_regbank, attached by bind. Relates bus writes
// to the request pulses and checks constant and reserved read values.
module sc_regbank_chk #(
    parameter int          ADDR_W = 6,
    parameter logic [31:0] SYS_ID = 32'h10014D31,
    parameter logic [31:0] CAPS   = 32'h0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       wdata_lo,
    input logic [31:0]       bus_rdata,
    input logic              sys_reset_req,
    input logic              shutdown_req
);
    localparam int WW = ADDR_W - 2;

    logic [WW-1:0] w;
    logic          al;
    logic          id_wr;
    logic          off_wr;
    logic          rsvd;

    assign w      = bus_addr[ADDR_W-1:2];
    assign al     = (bus_addr[1:0] == 2'b00);
    assign id_wr  = bus_valid && bus_write && al && (w == WW'(15));
    assign off_wr = bus_valid && bus_write && al && (w == WW'(13)) && (wdata_lo == 16'h000E);
    assign rsvd   = al && ((w == WW'(3)) || (w == WW'(7)) || (w == WW'(11)) || (w == WW'(12)));

    AST_RST_REQ_ISSUED:  assert property (@(posedge clk) disable iff (!rst_n) id_wr |=> sys_reset_req);        // R5
    AST_RST_REQ_CAUSE:   assert property (@(posedge clk) disable iff (!rst_n) sys_reset_req |-> $past(id_wr)); // R5
    AST_SHUT_REQ_ISSUED: assert property (@(posedge clk) disable iff (!rst_n) off_wr |=> shutdown_req);        // R6
    AST_SHUT_REQ_CAUSE:  assert property (@(posedge clk) disable iff (!rst_n) shutdown_req |-> $past(off_wr));  // R6
    AST_ID_STABLE:       assert property (@(posedge clk) disable iff (!rst_n) (al && w == WW'(15)) |-> bus_rdata == SYS_ID); // R3
    AST_CAPS_STABLE:     assert property (@(posedge clk) disable iff (!rst_n) (al && w == WW'(14)) |-> bus_rdata == CAPS);   // R3
    AST_RSVD_ZERO:       assert property (@(posedge clk) disable iff (!rst_n) rsvd |-> bus_rdata == 32'h0);  // R4
endmodule

bind sc_regbank sc_regbank_chk #(.ADDR_W(ADDR_W), .SYS_ID(SYS_ID), .CAPS(CAPS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_addr      (bus_addr),
    .wdata_lo      (bus_wdata[15:0]),
    .bus_rdata     (bus_rdata),
    .sys_reset_req (sys_reset_req),
    .shutdown_req  (shutdown_req)
);

// File: tb/sc_regbank_tb.sv
`timescale 1ns/1ps
module sc_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  gpio_in = 8'h3C;
    logic [7:0]  gpio_out;
    logic [7:0]  gpio_irq_en;
    logic [1:0]  timer_irq;
    logic        sys_reset_req;
    logic        shutdown_req;

    int total = 0;
    int bad = 0;
    logic [31:0] expw [16];

    localparam logic [31:0] ID = 32'h10014D31;

    always #10 clk = ~clk;

    sc_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_irq_en(gpio_irq_en),
        .timer_irq(timer_irq), .sys_reset_req(sys_reset_req), .shutdown_req(shutdown_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge.
    task automatic wr(input int w, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 6'(w * 4); bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int w, output logic [31:0] d);
        bus_addr = 6'(w * 4);
        #1 d = bus_rdata;
    endtask

    // Expected map contents after a write, from the requirements.
    function automatic void model_wr(input int w, input logic [31:0] d);
        case (w)
            1, 2:          expw[w] = {24'h0, d[7:0]};
            4, 8:          expw[w] = {30'h0, d[1:0]};
            5, 6, 9, 10:   expw[w] = d;
            default: ;
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int w;
        logic [31:0] d;
        void'($urandom(32'h1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset defaults (R2) and synchronizer latency (R7)
        rd(0, r);  chk("R2 strap", r, 32'h1);
        rd(13, r); chk("R2 cfg ready", r, 32'h1);
        rd(14, r); chk("R2 caps", r, 32'h0);
        rd(15, r); chk("R2 id", r, ID);
        rd(6, r);  chk("R2 timer cnt", r, 32'h0);
        chk("R2 outputs", {gpio_out, gpio_irq_en, 6'b0, timer_irq, sys_reset_req, shutdown_req}, 32'h0);
        @(negedge clk); rd(0, r); chk("R7 one edge", r, 32'h1);
        @(negedge clk); rd(0, r); chk("R7 two edges", r, 32'h3C);
        gpio_in = 8'hA5;
        @(negedge clk); rd(0, r); chk("R7 new one edge", r, 32'h3C);
        @(negedge clk); rd(0, r); chk("R7 new two edges", r, 32'hA5);

        // Random register traffic with timers kept disabled (R1 R3 R4 R8)
        for (int i = 0; i < 16; i++) expw[i] = 32'h0;
        expw[0] = 32'hA5; expw[13] = 32'h1; expw[14] = 32'h0; expw[15] = ID;
        for (int i = 0; i < 300; i++) begin
            w = int'($urandom_range(0, 14));
            if (w == 13) w = 3;
            d = $urandom;
            if (w == 4 || w == 8) d[0] = 1'b0;
            wr(w, d);
            model_wr(w, d);
            w = int'($urandom_range(0, 15));
            rd(w, r);
            chk("R1 R3 R4 R8 random readback", r, expw[w]);
        end
        chk("R1 gpio_out pin", {24'h0, gpio_out}, expw[1]);
        chk("R1 gpio_irq_en pin", {24'h0, gpio_irq_en}, expw[2]);

        // Directed map checks
        wr(1, 32'hFFFF_FF5A); rd(1, r); chk("R1 gpio out", r, 32'h5A);
        chk("R1 gpio pin", {24'h0, gpio_out}, 32'h5A);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 6'h05; bus_wdata = 32'h77;
        @(posedge clk); @(negedge clk); bus_valid = 1'b0; bus_write = 1'b0;
        rd(1, r); chk("R1 misaligned write ignored", r, 32'h5A);
        bus_addr = 6'h05; #1 chk("R1 misaligned read zero", bus_rdata, 32'h0);
        wr(0, 32'hFFFF_FFFF); rd(0, r); chk("R3 gpio in ro", r, 32'hA5);
        wr(14, 32'hDEAD_BEEF); rd(14, r); chk("R3 caps ro", r, 32'h0);
        wr(3, 32'hFFFF_FFFF); rd(3, r); chk("R4 reserved", r, 32'h0);
        wr(12, 32'h1234_5678); rd(12, r); chk("R4 reserved 12", r, 32'h0);

        // Reset request (R5)
        wr(15, 32'h0);
        chk("R5 pulse high", {31'h0, sys_reset_req}, 32'h1);
        rd(15, r); chk("R3 id unchanged", r, ID);
        @(negedge clk); chk("R5 pulse low", {31'h0, sys_reset_req}, 32'h0);

        // Shutdown request (R6)
        wr(13, 32'hABCD_000E);
        chk("R6 shutdown high", {31'h0, shutdown_req}, 32'h1);
        @(negedge clk); chk("R6 shutdown low", {31'h0, shutdown_req}, 32'h0);
        wr(13, 32'h0000_000F);
        chk("R6 wrong code", {31'h0, shutdown_req}, 32'h0);
        rd(13, r); chk("R3 cfg ro", r, 32'h1);

        // Timer 0 one-shot (R8 R9)
        wr(5, 32'd5); wr(6, 32'd0); wr(4, 32'h1);
        rd(6, r); chk("R8 start count", r, 32'd0);
        repeat (3) @(negedge clk); rd(6, r); chk("R8 live count", r, 32'd3);
        repeat (2) @(negedge clk); rd(6, r); chk("R8 at compare", r, 32'd5);
        chk("R9 irq before match", {30'h0, timer_irq}, 32'h0);
        @(negedge clk);
        chk("R9 irq on match", {30'h0, timer_irq}, 32'h1);
        rd(6, r); chk("R9 count cleared", r, 32'd0);
        rd(4, r); chk("R9 enable cleared", r, 32'h0);
        @(negedge clk);
        chk("R9 irq one cycle", {30'h0, timer_irq}, 32'h0);
        rd(6, r); chk("R9 stopped", r, 32'd0);

        // Timer 1 auto-restart (R9)
        wr(9, 32'd2); wr(10, 32'd0); wr(8, 32'h3);
        repeat (3) @(negedge clk);
        chk("R9 t1 irq", {30'h0, timer_irq}, 32'h2);
        @(negedge clk); rd(10, r); chk("R9 t1 restart", r, 32'd1);
        chk("R9 t1 irq low", {30'h0, timer_irq}, 32'h0);
        repeat (2) @(negedge clk);
        chk("R9 t1 second irq", {30'h0, timer_irq}, 32'h2);
        rd(8, r); chk("R9 t1 still enabled", r, 32'h3);
        wr(8, 32'h0);

        // Write and match on the same edge (R10)
        wr(5, 32'd3); wr(6, 32'd0); wr(4, 32'h3);
        repeat (3) @(negedge clk); rd(6, r); chk("R10 at compare", r, 32'd3);
        wr(4, 32'h3);
        chk("R10 no irq on write", {30'h0, timer_irq}, 32'h0);
        rd(6, r); chk("R10 count held", r, 32'd3);
        @(negedge clk);
        chk("R10 match next edge", {30'h0, timer_irq}, 32'h1);
        rd(6, r); chk("R10 count cleared", r, 32'd0);
        wr(4, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule